// File: doc/BRIEF.md
# SPI Word Host Engine

This block is a single-command SPI host. It moves one word per request between a parallel transmit input and a parallel receive output. It generates the serial clock, drives the data-out line, samples the data-in line and drives one of four chip-select outputs. A one-cycle valid strobe starts each word, and a one-cycle ready strobe reports that the received word is available.

Static configuration inputs set the following:
- clock polarity and clock phase;
- bit order;
- frame length, from 4 to 32 bits;
- which select line is used, and the active level of each line;
- a keep-asserted option, so that several words form one message;
- an auto-stop option, which holds off new words while a received word has not been read;
- a two-stage bit-rate divisor.

Configuration may change only while the enable input is low.

Top module: `spi_word_host`

## Requirements
- R1: Each half serial-clock period lasts H = (div_n_i+1) * 2^div_e_i input clocks (div_n_i 0..255, div_e_i 0..3). A word takes (2B+2)*H cycles from the edge that accepts tx_valid_i to the edge that raises rx_ready_o. That time is one H of select lead, 2B clock edges, and one H of trail.
- R2: Frame length B = flen_i+1 for flen_i 3..31, and flen_i 0..2 gives B = 4. Each word produces exactly 2B transitions on sclk_o.
- R3: sclk_o rests at cpol_i whenever the block is not busy. With cpha_i=0, data-in is sampled on the leading edge (the one leaving cpol_i) and the first bit is on mosi_o before that edge. With cpha_i=1, mosi_o changes on the leading edge and data-in is sampled on the trailing edge.
- R4: With lsb_first_i=1, bit 0 of the word is shifted first. With lsb_first_i=0, bit B-1 is shifted first. The k-th bit received lands in bit k (LSB first) or bit B-1-k (MSB first).
- R5: rx_data_o is right-aligned, with bits B and above zero. It changes only in the cycle where rx_ready_o is high, and rx_ready_o is a single-cycle pulse.
- R6: While a word is in progress, ss_o[sel_i] is at its active level and every other line is inactive. Line i is active low when sel_pol_i[i]=0 and active high when sel_pol_i[i]=1.
- R7: With keep_i=1 and tx_last_i=0 on the accepted word, the select line stays active after the word completes. With keep_i=0, or with tx_last_i=1, it goes inactive at the end of the trailing half period.
- R8: rx_pending_o rises with rx_ready_o and clears on rx_read_i. With auto_stop_i=1, tx_valid_i is ignored while rx_pending_o is high.
- R9: The cycle after en_i goes low, the block is idle, every select line is inactive and sclk_o equals cpol_i. tx_valid_i is ignored while en_i is low.
- R10: tx_valid_i asserted while a word is in progress is ignored. The running word's data and duration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Sample on second edge when 1 |
| lsb_first_i | input | 1 | Shift LSB first when 1 |
| flen_i | input | 5 | Bits per word minus one |
| sel_i | input | 2 | Select line number |
| sel_pol_i | input | 4 | Active level per select line |
| keep_i | input | 1 | Keep select asserted between words |
| auto_stop_i | input | 1 | Hold off new words while data is unread |
| div_n_i | input | 8 | Linear rate divisor |
| div_e_i | input | 2 | Power-of-two rate divisor |
| tx_valid_i | input | 1 | Start a word |
| tx_data_i | input | 32 | Word to send |
| tx_last_i | input | 1 | Word ends the message |
| rx_read_i | input | 1 | Received word consumed |
| busy_o | output | 1 | Word in progress |
| rx_ready_o | output | 1 | Received word strobe |
| rx_pending_o | output | 1 | Received word not yet read |
| rx_data_o | output | 32 | Received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 4 | Select lines |

## Verification
The assertions check the following on every cycle:
- the serial clock rests at its idle level while the block is not busy;
- only the chosen select line is active during a word;
- disabling the block returns it to idle;
- the ready strobe lasts a single cycle, and received data holds between strobes;
- received data has no bits above the frame;
- auto-stop holds off new words.

Only the bench scenarios show the rest: the exact word duration for a given divisor pair, the edge count, the bit order on the data-out line, the placement of received bits from a modelled peripheral under all four clock modes, keep-asserted messages, and busy-time requests being ignored.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_HOLD
  } host_state_e;
endpackage

// File: rtl/spi_rate_div.sv
`timescale 1ns/1ps
module spi_rate_div #(
  parameter int unsigned N_W = 8,
  parameter int unsigned E_W = 2,
  localparam int unsigned CNT_W = N_W + (1 << E_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [N_W-1:0] div_n_i,
  input  logic [E_W-1:0] div_e_i,
  output logic           tick_o
);
  logic [CNT_W-1:0] half, cnt_q;

  assign half   = (CNT_W'(div_n_i) + CNT_W'(1)) << div_e_i;
  assign tick_o = run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_word_ctrl.sv
`timescale 1ns/1ps
module spi_word_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned LEN_W = 5,
  localparam int unsigned EDGE_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  flen_i,
  input  logic              keep_i,
  input  logic              auto_stop_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  input  logic              rx_read_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              load_o,
  output logic              edge_o,
  output logic [EDGE_W-1:0] edge_idx_o,
  output logic              edge_last_o,
  output logic [LEN_W:0]    nbits_o,
  output logic              ss_on_o,
  output logic              phase_o,
  output logic              done_o,
  output logic              rx_ready_o,
  output logic              rx_pending_o
);
  host_state_e       state_q;
  logic [EDGE_W-1:0] edge_q, last_idx;
  logic              phase_q, ss_on_q, last_q, pend_q, ready_q;
  logic              idle_st, start;

  // short frames are clamped to the minimum of four bits
  assign nbits_o  = (flen_i < LEN_W'(3)) ? (LEN_W+1)'(4) : ({1'b0, flen_i} + (LEN_W+1)'(1));
  assign last_idx = EDGE_W'({nbits_o, 1'b0} - (LEN_W+2)'(1));

  assign idle_st = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign start   = en_i && tx_valid_i && idle_st && !(auto_stop_i && pend_q);

  assign run_o        = !idle_st;
  assign load_o       = start;
  assign edge_o       = (state_q == ST_SHIFT) && tick_i;
  assign edge_idx_o   = edge_q;
  assign edge_last_o  = (edge_q == last_idx);
  assign done_o       = en_i && (state_q == ST_TRAIL) && tick_i;
  assign ss_on_o      = ss_on_q;
  assign phase_o      = phase_q;
  assign rx_ready_o   = ready_q;
  assign rx_pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      phase_q <= 1'b0;
      ss_on_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      phase_q <= 1'b0;
      ss_on_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (start) begin
            state_q <= ST_LEAD;
            ss_on_q <= 1'b1;
            last_q  <= tx_last_i;
            edge_q  <= '0;
          end
        end
        ST_LEAD: begin
          if (tick_i) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick_i) begin
            phase_q <= ~phase_q;
            if (edge_last_o) begin
              state_q <= ST_TRAIL;
              edge_q  <= '0;
            end else begin
              edge_q <= edge_q + EDGE_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (tick_i) begin
            if (keep_i && !last_q) begin
              state_q <= ST_HOLD;
            end else begin
              state_q <= ST_IDLE;
              ss_on_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= done_o;
      if (done_o)         pend_q <= 1'b1;
      else if (rx_read_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_dp.sv
`timescale 1ns/1ps
module spi_shift_dp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5,
  localparam int unsigned EDGE_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic [LEN_W:0]    nbits_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              run_i,
  input  logic              edge_i,
  input  logic [EDGE_W-1:0] edge_idx_i,
  input  logic              edge_last_i,
  input  logic              done_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [DATA_W-1:0] tx_q, acc_q, rx_q;
  logic [LEN_W-1:0]  opos_q, ipos_q, oidx, iidx;
  logic              lead, smp, shf;

  // even edge index = leading edge
  assign lead = ~edge_idx_i[0];
  assign smp  = lead ^ cpha_i;
  assign shf  = cpha_i ? (lead && (edge_idx_i != '0)) : (!lead && !edge_last_i);

  assign oidx = lsb_first_i ? opos_q
              : LEN_W'(nbits_i - (LEN_W+1)'(1) - (LEN_W+1)'(opos_q));
  assign iidx = lsb_first_i ? ipos_q
              : LEN_W'(nbits_i - (LEN_W+1)'(1) - (LEN_W+1)'(ipos_q));

  assign mosi_o    = run_i & tx_q[oidx];
  assign rx_data_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      acc_q  <= '0;
      rx_q   <= '0;
      opos_q <= '0;
      ipos_q <= '0;
    end else begin
      if (load_i) begin
        tx_q   <= tx_data_i;
        acc_q  <= '0;
        opos_q <= '0;
        ipos_q <= '0;
      end else if (edge_i) begin
        if (smp) begin
          acc_q[iidx] <= miso_i;
          ipos_q      <= ipos_q + LEN_W'(1);
        end
        if (shf) opos_q <= opos_q + LEN_W'(1);
      end
      if (done_i) rx_q <= acc_q;
    end
  end
endmodule

// File: rtl/spi_sel_drive.sv
`timescale 1ns/1ps
module spi_sel_drive #(
  parameter int unsigned NUM_SEL = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SEL)
) (
  input  logic               ss_on_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SEL-1:0] pol_i,
  output logic [NUM_SEL-1:0] ss_o
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
    assign ss_o[i] = (ss_on_i && (sel_i == SEL_W'(i))) ? pol_i[i] : ~pol_i[i];
  end
endmodule

// File: rtl/spi_word_host.sv
`timescale 1ns/1ps
module spi_word_host
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned DIV_N_W = 8,
  parameter int unsigned DIV_E_W = 2,
  localparam int unsigned LEN_W  = $clog2(DATA_W),
  localparam int unsigned SEL_W  = $clog2(NUM_SEL),
  localparam int unsigned EDGE_W = LEN_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic [LEN_W-1:0]   flen_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SEL-1:0] sel_pol_i,
  input  logic               keep_i,
  input  logic               auto_stop_i,
  input  logic [DIV_N_W-1:0] div_n_i,
  input  logic [DIV_E_W-1:0] div_e_i,
  input  logic               tx_valid_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  input  logic               tx_last_i,
  input  logic               rx_read_i,
  output logic               busy_o,
  output logic               rx_ready_o,
  output logic               rx_pending_o,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_SEL-1:0] ss_o
);
  logic              run, tick, load, edge_tk, edge_last, done, ss_on, phase;
  logic [EDGE_W-1:0] edge_idx;
  logic [LEN_W:0]    nbits;

  spi_rate_div #(.N_W(DIV_N_W), .E_W(DIV_E_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .div_n_i (div_n_i),
    .div_e_i (div_e_i),
    .tick_o  (tick)
  );

  spi_word_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .flen_i       (flen_i),
    .keep_i       (keep_i),
    .auto_stop_i  (auto_stop_i),
    .tx_valid_i   (tx_valid_i),
    .tx_last_i    (tx_last_i),
    .rx_read_i    (rx_read_i),
    .tick_i       (tick),
    .run_o        (run),
    .load_o       (load),
    .edge_o       (edge_tk),
    .edge_idx_o   (edge_idx),
    .edge_last_o  (edge_last),
    .nbits_o      (nbits),
    .ss_on_o      (ss_on),
    .phase_o      (phase),
    .done_o       (done),
    .rx_ready_o   (rx_ready_o),
    .rx_pending_o (rx_pending_o)
  );

  spi_shift_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpha_i      (cpha_i),
    .lsb_first_i (lsb_first_i),
    .nbits_i     (nbits),
    .load_i      (load),
    .tx_data_i   (tx_data_i),
    .run_i       (run),
    .edge_i      (edge_tk),
    .edge_idx_i  (edge_idx),
    .edge_last_i (edge_last),
    .done_i      (done),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_data_o   (rx_data_o)
  );

  spi_sel_drive #(.NUM_SEL(NUM_SEL)) u_sel (
    .ss_on_i (ss_on),
    .sel_i   (sel_i),
    .pol_i   (sel_pol_i),
    .ss_o    (ss_o)
  );

  assign busy_o = run;
  assign sclk_o = cpol_i ^ phase;
endmodule

// File: rtl/spi_word_host_chk.sv
`timescale 1ns/1ps
module spi_word_host_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SEL = 4,
  localparam int unsigned LEN_W  = $clog2(DATA_W),
  localparam int unsigned SEL_W  = $clog2(NUM_SEL)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               cpol_i,
  input logic [LEN_W-1:0]   flen_i,
  input logic [SEL_W-1:0]   sel_i,
  input logic [NUM_SEL-1:0] sel_pol_i,
  input logic               auto_stop_i,
  input logic               busy_o,
  input logic               rx_ready_o,
  input logic               rx_pending_o,
  input logic [DATA_W-1:0]  rx_data_o,
  input logic               sclk_o,
  input logic [NUM_SEL-1:0] ss_o
);
  logic [NUM_SEL-1:0] idle_vec, act_vec;
  logic [LEN_W:0]     nb;

  assign idle_vec = ~sel_pol_i;
  assign act_vec  = idle_vec ^ (NUM_SEL'(1) << sel_i);
  assign nb       = (flen_i < LEN_W'(3)) ? (LEN_W+1)'(4) : ({1'b0, flen_i} + (LEN_W+1)'(1));

  a_r3_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o == cpol_i));

  a_r6_sel_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ss_o == act_vec));

  a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && (ss_o == idle_vec)));

  a_r5_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |=> !rx_ready_o);

  a_r5_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_o |-> $stable(rx_data_o));

  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> ((rx_data_o >> nb) == '0));

  a_r8_auto_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_stop_i && rx_pending_o && !busy_o) |=> !busy_o);
endmodule

bind spi_word_host spi_word_host_chk #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .cpol_i       (cpol_i),
  .flen_i       (flen_i),
  .sel_i        (sel_i),
  .sel_pol_i    (sel_pol_i),
  .auto_stop_i  (auto_stop_i),
  .busy_o       (busy_o),
  .rx_ready_o   (rx_ready_o),
  .rx_pending_o (rx_pending_o),
  .rx_data_o    (rx_data_o),
  .sclk_o       (sclk_o),
  .ss_o         (ss_o)
);

// File: tb/spi_word_host_test.sv
`timescale 1ns/1ps
module spi_word_host_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0;
  logic [4:0]  flen_i = 5'd7;
  logic [1:0]  sel_i = 2'd0;
  logic [3:0]  sel_pol_i = 4'h0;
  logic        keep_i = 1'b0, auto_stop_i = 1'b0;
  logic [7:0]  div_n_i = 8'd0;
  logic [1:0]  div_e_i = 2'd0;
  logic        tx_valid_i = 1'b0, tx_last_i = 1'b0, rx_read_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        busy_o, rx_ready_o, rx_pending_o, sclk_o, mosi_o, miso_i;
  logic [31:0] rx_data_o;
  logic [3:0]  ss_o;

  always #4 clk_i = ~clk_i;

  spi_word_host uut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit          mon_on = 0;
  int          sc = 0, ms = 0, edges = 0;
  logic [31:0] pat = '0, mseq = '0;

  // peripheral model: shifts pat out in time order, records mosi at sample edges
  always @(sclk_o) begin
    if (mon_on) begin
      edges++;
      if ((sclk_o != cpol_i) ^ cpha_i) begin
        if (ms < 32) mseq[ms] = mosi_o;
        ms++;
      end else begin
        sc++;
      end
    end
  end

  function automatic logic pat_bit(input logic [31:0] p, input int s, input logic ph);
    int i;
    i = ph ? s - 1 : s;
    return (i >= 0 && i < 32) ? p[i] : 1'b0;
  endfunction

  assign miso_i = pat_bit(pat, sc, cpha_i);

  function automatic int nbits_f(input int fl);
    return (fl < 3) ? 4 : fl + 1;
  endfunction

  function automatic logic [31:0] exp_mosi(input logic [31:0] tx, input int b, input logic lsb);
    logic [31:0] r = '0;
    for (int k = 0; k < b; k++) r[k] = lsb ? tx[k] : tx[b-1-k];
    return r;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] p, input int b, input logic lsb);
    logic [31:0] r = '0;
    for (int k = 0; k < b; k++) begin
      if (lsb) r[k] = p[k];
      else     r[b-1-k] = p[k];
    end
    return r;
  endfunction

  function automatic logic [3:0] act_vec();
    return (~sel_pol_i) ^ (4'b1 << sel_i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cycle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic lsb, input logic [4:0] fl,
                         input logic [1:0] sel, input logic [3:0] sp, input logic kp,
                         input logic as, input logic [7:0] n, input logic [1:0] e);
    en_i = 1'b0;
    cycle();
    cpol_i = pol; cpha_i = pha; lsb_first_i = lsb; flen_i = fl; sel_i = sel;
    sel_pol_i = sp; keep_i = kp; auto_stop_i = as; div_n_i = n; div_e_i = e;
    cycle();
    en_i = 1'b1;
    cycle();
  endtask

  task automatic run_word(input logic [31:0] tx, input bit last, input bit poke, output int k);
    pat = $urandom; sc = 0; ms = 0; edges = 0; mseq = '0; mon_on = 1;
    tx_data_i = tx; tx_last_i = last; tx_valid_i = 1'b1;
    cycle();
    tx_valid_i = 1'b0; tx_data_i = ~tx;
    k = 0;
    while (!rx_ready_o && k < 40000) begin
      tx_valid_i = (poke && k == 2);
      if (k == 1) chk(ss_o == act_vec(), "R6 select during word", 32'(ss_o), 32'(act_vec()));
      cycle();
      k++;
    end
    tx_valid_i = 1'b0;
    mon_on = 0;
  endtask

  task automatic check_word(input logic [31:0] tx, input int k, input bit held);
    int b, h;
    b = nbits_f(int'(flen_i));
    h = (int'(div_n_i) + 1) << div_e_i;
    chk(k == (2*b+2)*h, "R1 word duration", 32'(k), 32'((2*b+2)*h));
    chk(edges == 2*b, "R2 sclk transitions", 32'(edges), 32'(2*b));
    chk(mseq == exp_mosi(tx, b, lsb_first_i), "R4 mosi bit order R3 mode", mseq, exp_mosi(tx, b, lsb_first_i));
    chk(rx_data_o == exp_rx(pat, b, lsb_first_i), "R5 rx word R4 order", rx_data_o, exp_rx(pat, b, lsb_first_i));
    chk(sclk_o == cpol_i, "R3 sclk idle", 32'(sclk_o), 32'(cpol_i));
    if (held) chk(ss_o == act_vec(), "R7 select kept", 32'(ss_o), 32'(act_vec()));
    else      chk(ss_o == ~sel_pol_i, "R7 select released", 32'(ss_o), 32'(~sel_pol_i));
  endtask

  task automatic do_read();
    rx_read_i = 1'b1;
    cycle();
    rx_read_i = 1'b0;
    chk(rx_ready_o == 1'b0, "R5 ready pulse", 32'(rx_ready_o), 32'd0);
    chk(rx_pending_o == 1'b0, "R8 pending cleared", 32'(rx_pending_o), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    logic [31:0] w;
    repeat (3) @(negedge clk_i);
    // reset state
    chk(busy_o == 1'b0, "R9 reset idle", 32'(busy_o), 32'd0);
    chk(ss_o == 4'hF, "R6 reset select inactive", 32'(ss_o), 32'hF);
    chk(sclk_o == 1'b0, "R3 reset sclk", 32'(sclk_o), 32'd0);
    chk(rx_data_o == '0, "R5 reset rx", rx_data_o, 32'd0);
    chk(rx_ready_o == 1'b0, "R5 reset ready", 32'(rx_ready_o), 32'd0);
    rst_ni = 1'b1;
    cycle();

    void'($urandom(32'h5A17));

    // random words across modes, orders, lengths and rates
    for (int i = 0; i < 24; i++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom),
              4'($urandom), 1'b0, 1'b0, 8'($urandom % 4), 2'($urandom));
      w = $urandom;
      run_word(w, 1'b0, 1'b0, k);
      check_word(w, k, 1'b0);
      do_read();
    end

    // all four modes, fixed 8-bit frame, both orders
    for (int m = 0; m < 8; m++) begin
      set_cfg(1'(m >> 1), 1'(m), 1'(m >> 2), 5'd7, 2'(m), 4'(m * 5), 1'b0, 1'b0, 8'd1, 2'd0);
      w = 32'hA5 ^ 32'(m * 17);
      run_word(w, 1'b0, 1'b0, k);
      check_word(w, k, 1'b0);
      do_read();
    end

    // R2: short field clamps to four bits; full 32-bit frame
    set_cfg(1'b0, 1'b0, 1'b0, 5'd1, 2'd2, 4'h0, 1'b0, 1'b0, 8'd0, 2'd1);
    run_word(32'hFFFF_FFF9, 1'b0, 1'b0, k);
    check_word(32'hFFFF_FFF9, k, 1'b0);
    do_read();
    set_cfg(1'b1, 1'b1, 1'b1, 5'd31, 2'd3, 4'h8, 1'b0, 1'b0, 8'd0, 2'd0);
    run_word(32'hDEAD_BEEF, 1'b0, 1'b0, k);
    check_word(32'hDEAD_BEEF, k, 1'b0);
    do_read();

    // R1: largest divisor
    set_cfg(1'b0, 1'b1, 1'b0, 5'd3, 2'd1, 4'h2, 1'b0, 1'b0, 8'd255, 2'd3);
    run_word(32'h0000_0006, 1'b0, 1'b0, k);
    check_word(32'h0000_0006, k, 1'b0);
    do_read();

    // R7: keep select between words of one message
    set_cfg(1'b0, 1'b0, 1'b0, 5'd7, 2'd1, 4'h2, 1'b1, 1'b0, 8'd1, 2'd0);
    run_word(32'h3C, 1'b0, 1'b0, k);
    check_word(32'h3C, k, 1'b1);
    repeat (4) cycle();
    chk(ss_o == act_vec(), "R7 select held between words", 32'(ss_o), 32'(act_vec()));
    do_read();
    run_word(32'hC3, 1'b1, 1'b0, k);
    check_word(32'hC3, k, 1'b0);
    do_read();

    // R10: request while busy is ignored
    set_cfg(1'b1, 1'b0, 1'b1, 5'd11, 2'd0, 4'h0, 1'b0, 1'b0, 8'd2, 2'd0);
    run_word(32'h5A3, 1'b0, 1'b1, k);
    check_word(32'h5A3, k, 1'b0);
    chk(busy_o == 1'b0, "R10 no second word", 32'(busy_o), 32'd0);
    do_read();

    // R8: auto-stop holds off while data unread
    set_cfg(1'b0, 1'b1, 1'b0, 5'd5, 2'd3, 4'h0, 1'b0, 1'b1, 8'd0, 2'd0);
    run_word(32'h2B, 1'b0, 1'b0, k);
    check_word(32'h2B, k, 1'b0);
    chk(rx_pending_o == 1'b1, "R8 pending set", 32'(rx_pending_o), 32'd1);
    tx_valid_i = 1'b1;
    cycle();
    tx_valid_i = 1'b0;
    repeat (3) cycle();
    chk(busy_o == 1'b0, "R8 start held off", 32'(busy_o), 32'd0);
    do_read();
    run_word(32'h14, 1'b0, 1'b0, k);
    check_word(32'h14, k, 1'b0);
    do_read();

    // R9: disable mid-word, then request while disabled
    set_cfg(1'b1, 1'b0, 1'b0, 5'd15, 2'd2, 4'h4, 1'b0, 1'b0, 8'd3, 2'd0);
    tx_data_i = 32'h1234; tx_valid_i = 1'b1;
    cycle();
    tx_valid_i = 1'b0;
    repeat (9) cycle();
    chk(busy_o == 1'b1, "R9 word running", 32'(busy_o), 32'd1);
    en_i = 1'b0;
    cycle();
    chk(busy_o == 1'b0, "R9 disabled idle", 32'(busy_o), 32'd0);
    chk(ss_o == ~sel_pol_i, "R9 select released", 32'(ss_o), 32'(~sel_pol_i));
    chk(sclk_o == cpol_i, "R9 sclk idle", 32'(sclk_o), 32'(cpol_i));
    tx_valid_i = 1'b1;
    cycle();
    tx_valid_i = 1'b0;
    cycle();
    chk(busy_o == 1'b0, "R9 request ignored", 32'(busy_o), 32'd0);
    chk(rx_ready_o == 1'b0, "R9 no ready", 32'(rx_ready_o), 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule